// File: doc/BRIEF.md
# Dual-Bank Flash Address Remapper

This block sits on the address path between the system bus and a flash array made of two equal physical halves, bank A and bank B. The bank that currently holds the running image is seen at logical address 0, and the other bank is seen in the upper half of the logical range. The remap is a single inversion of the bank-select address bit (the most significant address bit), driven by a swap flag. The low address bits pass through unchanged.

A one-cycle swap strobe flips the swap flag and, in the same clock edge, raises a reset request toward the system reset controller. No bus cycle can be issued between the two, so the swap and the reset form one indivisible action. The reset request stays high for a fixed number of cycles. The swap flag is cleared only by the power-on reset of this block, so the new mapping survives the system reset that the swap triggers. A status output tells software which physical bank is mapped at address 0.

Top module: `flash_bank_mapper`

## Requirements
- R1: While `por_n` is low, and after it is released, `bank_a_first` is 1, `reset_req` is 0 and `phys_addr` equals `bus_addr` (bank A mapped at logical 0).
- R2: `phys_addr` follows `bus_addr` in the same cycle. Bits ADDR_W-2..0 are copied unchanged, and bit ADDR_W-1 (the bank select, 0 = lower logical half) is inverted exactly when bank B is mapped first.
- R3: `bank_a_first` is 1 when physical bank A answers logical addresses 0 to half the flash size, and 0 when physical bank B does.
- R4: A swap strobe sampled high while `reset_req` is low inverts the mapping and raises `reset_req` at the same clock edge.
- R5: `reset_req` stays high for exactly REQ_CYCLES consecutive cycles after an accepted swap, then falls.
- R6: A swap strobe sampled while `reset_req` is high is ignored: the mapping and the length of the pulse do not change.
- R7: The swapped mapping holds after `reset_req` falls and is changed only by another accepted swap or by `por_n`.
- R8: The release of `por_n` is synchronised over SYNC_STAGES clock edges. A swap strobe in that window is ignored.
- R9: Two accepted swaps bring back the mapping with bank A first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| bus_addr | input | ADDR_W | Logical byte address from the bus |
| swap_cmd | input | 1 | Swap-and-reset strobe, one cycle |
| phys_addr | output | ADDR_W | Physical flash byte address |
| bank_a_first | output | 1 | 1 when bank A is mapped at address 0 |
| reset_req | output | 1 | System reset request, REQ_CYCLES long |

## Verification
The address path has no register, so `phys_addr` is due in the same cycle that `bus_addr` is applied. The status bit and the reset request change at the first rising edge where a strobe is accepted, and the request falls REQ_CYCLES edges later. After `por_n` rises, the block becomes active only at the edge after SYNC_STAGES edges. The bench drives inputs on the falling edge and compares all three outputs just after it. It keeps a behavioural model that it advances on each rising edge, so every value it compares already includes the register delays counted above.

// File: rtl/flash_map_pkg.sv
package flash_map_pkg;

  // Which physical bank answers the lower logical half.
  typedef enum logic {
    MAP_A_LOW = 1'b0,
    MAP_B_LOW = 1'b1
  } bank_map_e;

  function automatic bank_map_e map_flip(input bank_map_e m);
    return (m == MAP_A_LOW) ? MAP_B_LOW : MAP_A_LOW;
  endfunction

endpackage

// File: rtl/fbm_rst_sync.sv
module fbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sync_d[i] = 1'b1;
    end else begin : g_next
      assign sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/fbm_swap_state.sv
module fbm_swap_state
  import flash_map_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  output bank_map_e map_q
);

  bank_map_e map_d;
  logic      map_en;

  always_comb begin
    map_en = accept;
    map_d  = map_flip(map_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= MAP_A_LOW;
    end else if (map_en) begin
      map_q <= map_d;
    end
  end

endmodule

// File: rtl/fbm_req_timer.sv
module fbm_req_timer #(
  parameter int REQ_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(REQ_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(REQ_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             running;

  always_comb begin
    running = (cnt_q != '0);
    cnt_en  = start | running;
    if (start) begin
      cnt_d = LOAD_VAL;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = running;

endmodule

// File: rtl/fbm_addr_remap.sv
module fbm_addr_remap
  import flash_map_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  bank_map_e         map,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int SEL_BIT = ADDR_W - 1;

  logic flip;

  always_comb begin
    flip              = (map == MAP_B_LOW);
    addr_out          = addr_in;
    addr_out[SEL_BIT] = addr_in[SEL_BIT] ^ flip;
  end

endmodule

// File: rtl/flash_bank_mapper.sv
module flash_bank_mapper
  import flash_map_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int REQ_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              swap_cmd,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              bank_a_first,
  output logic              reset_req
);

  logic      rst_n_q;
  logic      busy;
  logic      accept;
  bank_map_e map_q;

  fbm_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk   (clk),
    .arst_n(por_n),
    .rst_n (rst_n_q)
  );

  assign accept = swap_cmd & ~busy;

  fbm_swap_state u_swap (
    .clk   (clk),
    .rst_n (rst_n_q),
    .accept(accept),
    .map_q (map_q)
  );

  fbm_req_timer #(
    .REQ_CYCLES(REQ_CYCLES)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n_q),
    .start(accept),
    .busy (busy)
  );

  fbm_addr_remap #(
    .ADDR_W(ADDR_W)
  ) u_remap (
    .addr_in (bus_addr),
    .map     (map_q),
    .addr_out(phys_addr)
  );

  assign bank_a_first = (map_q == MAP_A_LOW);
  assign reset_req    = busy;

endmodule

// File: rtl/flash_bank_mapper_chk.sv
module flash_bank_mapper_chk #(
  parameter int ADDR_W     = 20,
  parameter int REQ_CYCLES = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n_q,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              swap_cmd,
  input logic [ADDR_W-1:0] phys_addr,
  input logic              bank_a_first,
  input logic              reset_req
);

  logic armed;
  int   run_len;

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      armed   <= 1'b0;
      run_len <= 0;
    end else begin
      armed   <= 1'b1;
      run_len <= reset_req ? ((run_len < REQ_CYCLES + 2) ? run_len + 1 : run_len) : 0;
    end
  end

  // R1: reset state while the power-on reset is held
  always @(posedge clk) begin
    if (!por_n) begin
      a_r1_reset_state : assert (bank_a_first && !reset_req);
    end
  end

  // R2: address relation at the ports
  always @(posedge clk) begin
    if (rst_n_q) begin
      a_r2_addr_map : assert (
        (phys_addr[ADDR_W-2:0] == bus_addr[ADDR_W-2:0]) &&
        (phys_addr[ADDR_W-1] == (bus_addr[ADDR_W-1] ^ !bank_a_first)));
    end
  end

  // R4: accepted strobe flips mapping and raises the request together
  a_r4_swap_atomic : assert property (@(posedge clk) disable iff (!rst_n_q)
    (armed && swap_cmd && !reset_req) |=> (reset_req && (bank_a_first != $past(bank_a_first))));

  // R5: request pulse has exactly REQ_CYCLES cycles
  a_r5_pulse_len : assert property (@(posedge clk) disable iff (!rst_n_q)
    $fell(reset_req) |-> (run_len == REQ_CYCLES));

  // R6: strobe during the request leaves the mapping alone
  a_r6_ignore_busy : assert property (@(posedge clk) disable iff (!rst_n_q)
    (swap_cmd && reset_req) |=> $stable(bank_a_first));

  // R7: mapping only moves on an accepted strobe
  a_r7_hold_map : assert property (@(posedge clk) disable iff (!rst_n_q)
    (armed && !(swap_cmd && !reset_req)) |=> $stable(bank_a_first));

endmodule

bind flash_bank_mapper flash_bank_mapper_chk #(
  .ADDR_W    (ADDR_W),
  .REQ_CYCLES(REQ_CYCLES)
) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .rst_n_q     (rst_n_q),
  .bus_addr    (bus_addr),
  .swap_cmd    (swap_cmd),
  .phys_addr   (phys_addr),
  .bank_a_first(bank_a_first),
  .reset_req   (reset_req)
);

// File: tb/flash_bank_mapper_test.sv
`timescale 1ns/1ps
module flash_bank_mapper_test;

  localparam int ADDR_W      = 20;
  localparam int REQ_CYCLES  = 16;
  localparam int SYNC_STAGES = 2;

  logic              clk;
  logic              por_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              swap_cmd;
  logic [ADDR_W-1:0] phys_addr;
  logic              bank_a_first;
  logic              reset_req;

  flash_bank_mapper #(
    .ADDR_W     (ADDR_W),
    .REQ_CYCLES (REQ_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) uut (
    .clk         (clk),
    .por_n       (por_n),
    .bus_addr    (bus_addr),
    .swap_cmd    (swap_cmd),
    .phys_addr   (phys_addr),
    .bank_a_first(bank_a_first),
    .reset_req   (reset_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_vec  = 0;
  int n_bad  = 0;
  bit done   = 0;
  int m_swap = 0;
  int m_cnt  = 0;
  int m_sync = 0;

  task automatic report(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: inputs applied at the falling edge, outputs compared,
  // model advanced at the rising edge.
  task automatic tick(input logic por, input logic cmd, input string tag);
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] exp_addr;
    a        = ADDR_W'($urandom);
    por_n    = por;
    bus_addr = a;
    swap_cmd = cmd;
    #1;
    if (!por) begin
      m_swap = 0;
      m_cnt  = 0;
      m_sync = 0;
    end
    exp_addr = a;
    exp_addr[ADDR_W-1] = a[ADDR_W-1] ^ m_swap[0];
    report(tag, "phys_addr", int'(phys_addr), int'(exp_addr));
    report(tag, "bank_a_first", int'(bank_a_first), (m_swap == 0) ? 1 : 0);
    report(tag, "reset_req", int'(reset_req), (m_cnt > 0) ? 1 : 0);
    @(posedge clk);
    if (por) begin
      if (m_sync >= SYNC_STAGES) begin
        if (m_cnt > 0) m_cnt--;
        else if (cmd) begin
          m_swap ^= 1;
          m_cnt  = REQ_CYCLES;
        end
      end
      if (m_sync < SYNC_STAGES) m_sync++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0, tag);
  endtask

  initial begin
    por_n    = 1'b0;
    bus_addr = '0;
    swap_cmd = 1'b0;
    @(negedge clk);
    // R1: power-on reset held
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, "R1");
    // R8: strobes during the synchronised release are dropped
    for (int i = 0; i < SYNC_STAGES; i++) tick(1'b1, 1'b1, "R8");
    idle(3, "R1");
    // R2: address sweep with bank A first
    idle(30, "R2");
    // R4: accepted strobe
    tick(1'b1, 1'b1, "R4");
    // R3: status with bank B first
    idle(2, "R3");
    // R6: strobes during the request pulse
    for (int i = 0; i < REQ_CYCLES - 4; i++) tick(1'b1, 1'b1, "R6");
    // R5: remainder of the pulse and its fall
    idle(6, "R5");
    // R7: mapping held after the pulse
    idle(30, "R7");
    // R9: second swap restores bank A first
    tick(1'b1, 1'b1, "R9");
    idle(REQ_CYCLES + 4, "R9");
    // R4: strobe held high swaps once per pulse plus one cycle
    for (int i = 0; i < 3 * (REQ_CYCLES + 1); i++) tick(1'b1, 1'b1, "R4");
    idle(REQ_CYCLES + 2, "R5");
    // R1: power-on reset in the middle of a pulse clears the swap
    tick(1'b1, 1'b1, "R4");
    idle(3, "R5");
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, "R1");
    idle(8, "R1");
    idle(20, "R2");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule